// File: doc/BRIEF.md
# Consecutive-Breach Boost Controller

This block is a hardware governor that sits next to a single activity-monitor channel of a memory clock domain. When the monitor reports that the activity count has been above (or below) its watermark for several sampling periods in a row, software or a sequencer pulses `start_i` with the matching event flag. The controller then rescales its boost frequency with fixed percentage coefficients. It re-arms or masks the two consecutive-event interrupt enables, so that a saturated or fully decayed boost stops producing further events.

After each update, the controller publishes the frequency the clock should be moved to. This target is the moving average of the activity, converted into a sustainable frequency, plus the boost. It also publishes a fresh pair of average-count watermarks centred on the latest average. Separately, it keeps the raw (instantaneous) watermarks in step with the current clock frequency. Two coefficient sets are built in, and a select input chooses between them. Choosing the operating point and changing the clock are left to the surrounding logic.

All quantities are 32-bit unsigned values in kHz or in counts. Intermediate products are widened to 64 bits.

Top module: `boost_governor`

## Requirements
- R1: After reset the boost is 0, both enables (`en_above_o`, `en_below_o`) are 1, `done_o` is 0, and the target and all four watermarks are 0.
- R2: On an update with the upper flag, the boost becomes old*up/100 + 16000. When that sum is below the maximum frequency sampled at start, `en_above_o` is 1. `en_below_o` is always 1 after an upper update.
- R3: If the grown boost is greater than or equal to the maximum frequency, the boost is clamped to the maximum and `en_above_o` becomes 0.
- R4: On an update with only the lower flag, the boost becomes old*down/100 and `en_above_o` becomes 1. If the result is 8000 or more, `en_below_o` is 1.
- R5: If the decayed boost is below 8000, the boost becomes 0 and `en_below_o` becomes 0.
- R6: When both flags are set in one update, only the upper rule is applied.
- R7: An update with neither flag leaves the boost and both enables unchanged, and still refreshes the target and the average watermarks.
- R8: The target is ((avg/12) * (10000/up_threshold)) / 100 + boost. Each division truncates, and the sum uses the boost after this update.
- R9: With band = ((max*6)/1000)*12, the average upper watermark is avg + band. The average lower watermark is avg - band when avg >= band, and 0 otherwise.
- R10: The raw upper watermark is cur*12*up_threshold/100 and the raw lower watermark is cur*12*down_threshold/100. Both are recomputed one clock after `cur_khz_i` or `cfg_sel_i` changes.
- R11: `start_i` is sampled on a clock edge. `done_o` is high for exactly one cycle, two edges after that sampling edge, and all update outputs are valid from that cycle on.
- R12: `start_i` is ignored while an update is in progress, and a start raised during an update has no effect on the result.
- R13: `cfg_sel_i`=0 selects the set up 200%, down 50%, thresholds 60/40. `cfg_sel_i`=1 selects up 800%, down 90%, thresholds 27/10. For an update the set is taken at start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Update strobe |
| up_evt_i | input | 1 | Consecutive-upper event flag |
| dn_evt_i | input | 1 | Consecutive-lower event flag |
| avg_i | input | 32 | Moving-average activity count |
| cur_khz_i | input | 32 | Current clock frequency, kHz |
| max_khz_i | input | 32 | Maximum clock frequency, kHz |
| cfg_sel_i | input | 1 | Coefficient set select |
| boost_o | output | 32 | Boost frequency, kHz |
| target_o | output | 32 | Target frequency, kHz |
| raw_hi_o | output | 32 | Raw upper watermark |
| raw_lo_o | output | 32 | Raw lower watermark |
| avg_hi_o | output | 32 | Average upper watermark |
| avg_lo_o | output | 32 | Average lower watermark |
| en_above_o | output | 1 | Consecutive-upper interrupt enable |
| en_below_o | output | 1 | Consecutive-lower interrupt enable |
| done_o | output | 1 | One-cycle pulse when update outputs are valid |

## Verification
The hardest states to reach are the two self-masking corners. Saturation only appears after a chain of upper updates whose compounding overshoots the maximum. The snap to zero only appears after a long chain of lower updates that decays the boost below half a step. The stimulus drives such chains with both coefficient sets, so that the enable masks are observed as they fall and as they are re-armed. A start raised while an update is in progress, carrying the opposite flag, shows that the second strobe is dropped.

// File: rtl/gov_pkg.sv
package gov_pkg;

  typedef struct packed {
    logic [15:0] up_pct;
    logic [15:0] dn_pct;
    logic [7:0]  hi_thr;
    logic [7:0]  lo_thr;
  } coef_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BOOST = 2'd1,
    ST_OUT   = 2'd2
  } seq_t;

  function automatic coef_t coef_of(input logic sel);
    coef_t c;
    if (sel) begin
      c.up_pct = 16'd800;
      c.dn_pct = 16'd90;
      c.hi_thr = 8'd27;
      c.lo_thr = 8'd10;
    end else begin
      c.up_pct = 16'd200;
      c.dn_pct = 16'd50;
      c.hi_thr = 8'd60;
      c.lo_thr = 8'd40;
    end
    return c;
  endfunction

endpackage

// File: rtl/boost_step.sv
module boost_step #(
  parameter int W    = 32,
  parameter int STEP = 16000
) (
  input  logic [W-1:0] boost_in,
  input  logic         up,
  input  logic         dn,
  input  logic [15:0]  up_pct,
  input  logic [15:0]  dn_pct,
  input  logic [W-1:0] max_f,
  input  logic         ea_in,
  input  logic         eb_in,
  output logic [W-1:0] boost_out,
  output logic         ea_out,
  output logic         eb_out
);
  localparam int        WW   = 2 * W;
  localparam logic [WW-1:0] HUND = WW'(100);
  localparam logic [WW-1:0] STP  = WW'(STEP);
  localparam logic [WW-1:0] HALF = WW'(STEP / 2);

  logic [WW-1:0] grow, shrink;

  always_comb begin
    grow   = (WW'(boost_in) * WW'(up_pct)) / HUND + STP;
    shrink = (WW'(boost_in) * WW'(dn_pct)) / HUND;
    boost_out = boost_in;
    ea_out    = ea_in;
    eb_out    = eb_in;
    if (up) begin
      eb_out = 1'b1;
      if (grow >= WW'(max_f)) begin
        boost_out = max_f;
        ea_out    = 1'b0;
      end else begin
        boost_out = W'(grow);
        ea_out    = 1'b1;
      end
    end else if (dn) begin
      ea_out = 1'b1;
      if (shrink < HALF) begin
        boost_out = '0;
        eb_out    = 1'b0;
      end else begin
        boost_out = W'(shrink);
        eb_out    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/target_calc.sv
module target_calc #(
  parameter int W      = 32,
  parameter int PERIOD = 12
) (
  input  logic [W-1:0] avg,
  input  logic [7:0]   hi_thr,
  input  logic [W-1:0] boost,
  output logic [W-1:0] target
);
  localparam int WW = 2 * W;

  logic [W-1:0]  per_ms, sustain;
  logic [WW-1:0] scaled;

  always_comb begin
    per_ms  = avg / W'(PERIOD);
    sustain = W'(10000) / W'(hi_thr);
    scaled  = (WW'(per_ms) * WW'(sustain)) / WW'(100);
    target  = W'(scaled) + boost;
  end
endmodule

// File: rtl/raw_wmark.sv
module raw_wmark #(
  parameter int W      = 32,
  parameter int PERIOD = 12
) (
  input  logic [W-1:0] cur,
  input  logic [7:0]   hi_thr,
  input  logic [7:0]   lo_thr,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int WW = 2 * W;

  logic [WW-1:0] span;

  always_comb begin
    span = WW'(cur) * WW'(PERIOD);
    hi   = W'((span * WW'(hi_thr)) / WW'(100));
    lo   = W'((span * WW'(lo_thr)) / WW'(100));
  end
endmodule

// File: rtl/avg_band.sv
module avg_band #(
  parameter int W        = 32,
  parameter int PERIOD   = 12,
  parameter int PERMILLE = 6
) (
  input  logic [W-1:0] avg,
  input  logic [W-1:0] max_f,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  localparam int WW = 2 * W;

  logic [W-1:0] band;

  always_comb begin
    band = W'(((WW'(max_f) * WW'(PERMILLE)) / WW'(1000)) * WW'(PERIOD));
    hi   = avg + band;
    lo   = (avg >= band) ? (avg - band) : '0;
  end
endmodule

// File: rtl/boost_governor.sv
module boost_governor
  import gov_pkg::*;
#(
  parameter int W        = 32,
  parameter int STEP     = 16000,
  parameter int PERIOD   = 12,
  parameter int PERMILLE = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         up_evt_i,
  input  logic         dn_evt_i,
  input  logic [W-1:0] avg_i,
  input  logic [W-1:0] cur_khz_i,
  input  logic [W-1:0] max_khz_i,
  input  logic         cfg_sel_i,
  output logic [W-1:0] boost_o,
  output logic [W-1:0] target_o,
  output logic [W-1:0] raw_hi_o,
  output logic [W-1:0] raw_lo_o,
  output logic [W-1:0] avg_hi_o,
  output logic [W-1:0] avg_lo_o,
  output logic         en_above_o,
  output logic         en_below_o,
  output logic         done_o
);
  seq_t         st_q, st_d;
  logic         up_q, dn_q, sel_q, rsel_q;
  logic [W-1:0] avg_q, max_q, cur_q;
  logic [W-1:0] boost_q, boost_d, tgt_q, tgt_d;
  logic [W-1:0] ahi_q, ahi_d, alo_q, alo_d, rhi_q, rlo_q;
  logic         ea_q, ea_d, eb_q, eb_d, done_q, done_d;
  logic         take_evt, take_raw;

  coef_t        evt_cf, raw_cf;
  logic [W-1:0] nb_boost, nb_tgt, nb_ahi, nb_alo, nb_rhi, nb_rlo;
  logic         nb_ea, nb_eb;

  assign evt_cf = coef_of(sel_q);
  assign raw_cf = coef_of(cfg_sel_i);

  boost_step #(.W(W), .STEP(STEP)) u_step (
    .boost_in(boost_q), .up(up_q), .dn(dn_q),
    .up_pct(evt_cf.up_pct), .dn_pct(evt_cf.dn_pct), .max_f(max_q),
    .ea_in(ea_q), .eb_in(eb_q),
    .boost_out(nb_boost), .ea_out(nb_ea), .eb_out(nb_eb)
  );

  target_calc #(.W(W), .PERIOD(PERIOD)) u_tgt (
    .avg(avg_q), .hi_thr(evt_cf.hi_thr), .boost(boost_q), .target(nb_tgt)
  );

  avg_band #(.W(W), .PERIOD(PERIOD), .PERMILLE(PERMILLE)) u_band (
    .avg(avg_q), .max_f(max_q), .hi(nb_ahi), .lo(nb_alo)
  );

  raw_wmark #(.W(W), .PERIOD(PERIOD)) u_raw (
    .cur(cur_khz_i), .hi_thr(raw_cf.hi_thr), .lo_thr(raw_cf.lo_thr),
    .hi(nb_rhi), .lo(nb_rlo)
  );

  always_comb begin
    st_d     = st_q;
    boost_d  = boost_q;
    ea_d     = ea_q;
    eb_d     = eb_q;
    tgt_d    = tgt_q;
    ahi_d    = ahi_q;
    alo_d    = alo_q;
    done_d   = 1'b0;
    take_evt = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          take_evt = 1'b1;
          st_d     = ST_BOOST;
        end
      end
      ST_BOOST: begin
        boost_d = nb_boost;
        ea_d    = nb_ea;
        eb_d    = nb_eb;
        st_d    = ST_OUT;
      end
      ST_OUT: begin
        tgt_d  = nb_tgt;
        ahi_d  = nb_ahi;
        alo_d  = nb_alo;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    take_raw = (cur_khz_i != cur_q) || (cfg_sel_i != rsel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      sel_q   <= 1'b0;
      avg_q   <= '0;
      max_q   <= '0;
      boost_q <= '0;
      ea_q    <= 1'b1;
      eb_q    <= 1'b1;
      tgt_q   <= '0;
      ahi_q   <= '0;
      alo_q   <= '0;
      done_q  <= 1'b0;
      cur_q   <= '0;
      rsel_q  <= 1'b0;
      rhi_q   <= '0;
      rlo_q   <= '0;
    end else begin
      st_q    <= st_d;
      boost_q <= boost_d;
      ea_q    <= ea_d;
      eb_q    <= eb_d;
      tgt_q   <= tgt_d;
      ahi_q   <= ahi_d;
      alo_q   <= alo_d;
      done_q  <= done_d;
      if (take_evt) begin
        up_q  <= up_evt_i;
        dn_q  <= dn_evt_i;
        sel_q <= cfg_sel_i;
        avg_q <= avg_i;
        max_q <= max_khz_i;
      end
      if (take_raw) begin
        cur_q  <= cur_khz_i;
        rsel_q <= cfg_sel_i;
        rhi_q  <= nb_rhi;
        rlo_q  <= nb_rlo;
      end
    end
  end

  assign boost_o    = boost_q;
  assign target_o   = tgt_q;
  assign raw_hi_o   = rhi_q;
  assign raw_lo_o   = rlo_q;
  assign avg_hi_o   = ahi_q;
  assign avg_lo_o   = alo_q;
  assign en_above_o = ea_q;
  assign en_below_o = eb_q;
  assign done_o     = done_q;
endmodule

// File: rtl/gov_checker.sv
module gov_checker
  import gov_pkg::*;
#(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input seq_t         st,
  input logic         up_q,
  input logic         dn_q,
  input logic [W-1:0] max_q,
  input logic [W-1:0] boost,
  input logic         en_above,
  input logic         en_below,
  input logic         done
);
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_DONE_AFTER_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == ST_OUT)); // R11
  AST_BOOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_BOOST) |=> $stable(boost)); // R12
  AST_SAT_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_above) |-> (boost == max_q)); // R3
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_below) |-> (boost == '0)); // R5
  AST_UP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BOOST && up_q) |=> en_below); // R2
  AST_DN_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BOOST && dn_q && !up_q) |=> en_above); // R4
endmodule

bind boost_governor gov_checker #(.W(W)) u_gov_chk (
  .clk(clk), .rst_n(rst_n), .st(st_q), .up_q(up_q), .dn_q(dn_q),
  .max_q(max_q), .boost(boost_o), .en_above(en_above_o),
  .en_below(en_below_o), .done(done_o)
);

// File: tb/tb_boost_governor.sv
module tb_boost_governor;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] boost, target, ahi, alo;
    logic        ea, eb;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, up_evt_i = 1'b0, dn_evt_i = 1'b0, cfg_sel_i = 1'b0;
  logic [31:0] avg_i = '0, cur_khz_i = '0, max_khz_i = '0;
  logic [31:0] boost_o, target_o, raw_hi_o, raw_lo_o, avg_hi_o, avg_lo_o;
  logic        en_above_o, en_below_o, done_o;

  int checks = 0, errors = 0, pushes = 0, dones = 0;
  exp_t q[$];
  longint m_boost = 0;
  logic   m_ea = 1'b1, m_eb = 1'b1;

  boost_governor dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // expected result of one update, from the requirements (R2-R9, R13)
  task automatic model(input logic up, input logic dn, input logic sel,
                       input longint avg, input longint mx, input string tag);
    exp_t e;
    longint upc, dnc, thr, g, s, band;
    upc = sel ? 800 : 200;
    dnc = sel ? 90 : 50;
    thr = sel ? 27 : 60;
    if (up) begin
      g = m_boost * upc / 100 + 16000;
      m_eb = 1'b1;
      if (g >= mx) begin m_boost = mx; m_ea = 1'b0; end
      else begin m_boost = g; m_ea = 1'b1; end
    end else if (dn) begin
      s = m_boost * dnc / 100;
      m_ea = 1'b1;
      if (s < 8000) begin m_boost = 0; m_eb = 1'b0; end
      else begin m_boost = s; m_eb = 1'b1; end
    end
    band = (mx * 6 / 1000) * 12;
    e.boost  = 32'(m_boost);
    e.ea     = m_ea;
    e.eb     = m_eb;
    e.target = 32'((avg / 12) * (10000 / thr) / 100 + m_boost);
    e.ahi    = 32'(avg + band);
    e.alo    = (avg >= band) ? 32'(avg - band) : 32'd0;
    e.tag    = tag;
    q.push_back(e);
    pushes++;
  endtask

  // driver: one update; extra=1 raises a second start with the opposite flags while busy
  task automatic ev(input logic up, input logic dn, input logic sel,
                    input logic [31:0] avg, input logic extra, input string tag);
    model(up, dn, sel, avg, max_khz_i, tag);
    start_i = 1'b1; up_evt_i = up; dn_evt_i = dn; cfg_sel_i = sel; avg_i = avg;
    @(negedge clk);
    chk("R11 done low after start edge", done_o, 0);
    if (extra) begin
      up_evt_i = ~up; dn_evt_i = ~dn; avg_i = avg + 32'd5000; cfg_sel_i = ~sel;
    end else start_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    chk("R11 done low one edge later", done_o, 0);
    @(negedge clk);
    chk("R11 done high two edges after start", done_o, 1);
    @(negedge clk);
    chk("R11 done single cycle", done_o, 0);
    cfg_sel_i = 1'b0;
  endtask

  // monitor/scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      dones++;
      if (q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " boost"}, boost_o, e.boost);
        chk({e.tag, " en_above"}, en_above_o, e.ea);
        chk({e.tag, " en_below"}, en_below_o, e.eb);
        chk({"R8 target ", e.tag}, target_o, e.target);
        chk({"R9 avg_hi ", e.tag}, avg_hi_o, e.ahi);
        chk({"R9 avg_lo ", e.tag}, avg_lo_o, e.alo);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    max_khz_i = 32'd400000;
    cur_khz_i = 32'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 boost", boost_o, 0);
    chk("R1 en_above", en_above_o, 1);
    chk("R1 en_below", en_below_o, 1);
    chk("R1 done", done_o, 0);
    chk("R1 target", target_o, 0);
    chk("R1 avg_hi", avg_hi_o, 0);
    chk("R1 raw_hi", raw_hi_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 raw watermarks track cur and set
    cur_khz_i = 32'd200000;
    @(negedge clk);
    chk("R10 raw_hi set0", raw_hi_o, 1440000);
    chk("R10 raw_lo set0", raw_lo_o, 960000);
    cur_khz_i = 32'd100000;
    chk("R10 raw_hi before edge", raw_hi_o, 1440000);
    @(negedge clk);
    chk("R10 raw_hi new cur", raw_hi_o, 720000);
    chk("R10 raw_lo new cur", raw_lo_o, 480000);
    cfg_sel_i = 1'b1;
    @(negedge clk);
    chk("R13 raw_hi set1", raw_hi_o, 324000);
    chk("R13 raw_lo set1", raw_lo_o, 120000);
    cfg_sel_i = 1'b0;
    @(negedge clk);

    // R2/R3 growth to saturation with set 0
    ev(1, 0, 0, 32'd1200000, 0, "R2 up 0");
    ev(1, 0, 0, 32'd1200000, 0, "R2 up 1");
    ev(1, 0, 0, 32'd900000, 0, "R2 up 2");
    ev(1, 0, 0, 32'd20000, 0, "R2 up 3");
    ev(1, 0, 0, 32'd10000, 0, "R3 saturate");
    chk("R3 en_above masked", en_above_o, 0);
    chk("R3 boost at max", boost_o, 400000);
    // R4/R5 decay to zero
    ev(0, 1, 0, 32'd500000, 0, "R4 down 0");
    for (int i = 0; i < 5; i++) ev(0, 1, 0, 32'd300000, 0, "R4 down chain");
    chk("R5 boost zero", boost_o, 0);
    chk("R5 en_below masked", en_below_o, 0);
    // R6 priority, R7 neither
    ev(1, 1, 0, 32'd600000, 0, "R6 both flags");
    ev(0, 0, 0, 32'd777777, 0, "R7 neither flag");
    // R13 second set
    ev(1, 0, 1, 32'd1500000, 0, "R13 up set1");
    ev(1, 0, 1, 32'd1500000, 0, "R13 up set1 sat");
    ev(0, 1, 1, 32'd2000000, 0, "R13 down set1");
    ev(0, 1, 1, 32'd40, 0, "R13 down set1 small avg");
    // R12 start while busy ignored
    ev(1, 0, 0, 32'd123456, 1, "R12 busy start ignored");
    ev(0, 1, 0, 32'd654321, 1, "R12 busy start ignored dn");
    repeat (4) @(negedge clk);
    chk("R12 no extra done", dones, pushes);
    chk("R12 scoreboard empty", q.size(), 0);
    summary();
  end
endmodule